// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

A small word-addressed memory shared by several requesters. Besides plain loads and stores it offers an indivisible compare-and-swap: the requester gives an address, an expected value and a replacement value. The unit fetches the word and compares it with the expected value. It stores the replacement only when the two are equal. It always reports the value it found, together with a flag that says whether the store took place.

Each requester owns a request channel with valid/ready handshaking. A request is taken on a clock edge where both valid and ready are high. While valid is high and ready is low, the requester must hold every request field steady. Ready is produced in the same cycle from the valids, by a round-robin arbiter, and at most one requester sees ready per cycle. Responses come back on a shared data/flag bus with a per-requester valid pulse. Responses cannot be back-pressured: a requester must take a response in the cycle its valid bit is high.

A swap holds the whole unit for two cycles, a fetch cycle and a conditional-store cycle. No request from anyone is accepted in the second cycle, so no other access can reach the word between the fetch and the store. Memory contents are cleared by reset.

Top module: `casmem_unit`

## Requirements
- R1: An accepted read (op code 0, or the unused code 3) drives the addressed word on rsp_data and sets the requester's rsp_valid bit for exactly the one cycle after acceptance, with rsp_swapped low.
- R2: An accepted write (op code 1) stores req_wdata at the address and produces no response pulse; a later read of that address returns the stored value.
- R3: An accepted swap (op code 2) whose stored word equals req_cmp replaces the word with req_wdata. Two cycles after acceptance it pulses the requester's rsp_valid with the old word on rsp_data and rsp_swapped high.
- R4: A swap whose stored word differs from req_cmp leaves memory unchanged. Its response has the same timing as in R3, carries the old word, and has rsp_swapped low.
- R5: In the cycle after a swap is accepted, req_ready is low for every requester, so another request to the same word is only taken after the swap has stored its result.
- R6: When several requesters are valid, the grant goes to the first valid requester after the most recently granted one, in cyclic index order.
- R7: req_ready is one-hot or zero and is only raised toward a valid requester. When the unit is not in a swap's second cycle and any requester is valid, one of them is granted.
- R8: At most one bit of rsp_valid is high in any cycle, and it belongs to the requester that issued the request.
- R9: After reset, every word reads as zero, no response is pending, and requester 0 has the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NREQ | Per-requester request valid |
| req_ready | output | NREQ | Per-requester grant; a request is taken when valid and ready are both high |
| req_op | input | 2*NREQ | Operation per requester: 0 read, 1 write, 2 swap, 3 read |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write data, or the replacement value for a swap |
| req_cmp | input | DW*NREQ | Expected value for a swap |
| rsp_valid | output | NREQ | One-cycle response pulse, one bit per requester |
| rsp_data | output | DW | Word read, or the old word for a swap |
| rsp_swapped | output | 1 | High with a swap response whose store happened |

## Verification
The hardest state to reach from the ports is a second requester contending for a word while a swap is between its fetch and its store. Only in that case does the lock visibly hold anything off. The bench starts a swap alone, then raises a read to the same word in the swap's second cycle. It checks that ready stays low in that cycle, that the read is granted in the following cycle, and that the read returns the replacement value. A table of single-requester operations covers matching and mismatching swaps at both ends of the address range. A phase with all requesters valid together checks the rotation order.

// File: rtl/casmem_pkg.sv
package casmem_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CAS   = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_CAS_WR = 1'b1
  } st_e;
endpackage

// File: rtl/casmem_rr_arb.sv
module casmem_rr_arb #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_any
);
  logic [IDX_W-1:0] last;

  // search starts just after the last winner and wraps around
  always_comb begin
    int c;
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    c       = 0;
    if (en) begin
      for (int k = 1; k <= N; k++) begin
        c = int'(last) + k;
        if (c >= N) c = c - N;
        if (!gnt_any && req[c]) begin
          gnt[c]  = 1'b1;
          gnt_idx = IDX_W'(c);
          gnt_any = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last <= IDX_W'(N - 1);
    else if (gnt_any) last <= gnt_idx;
  end
endmodule

// File: rtl/casmem_store.sv
module casmem_store #(
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] words [DEPTH];

  assign rd_data = words[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/casmem_unit.sv
module casmem_unit
  import casmem_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  output logic [NREQ-1:0]    req_ready,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  input  logic [DW*NREQ-1:0] req_cmp,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_swapped
);
  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  // per-requester views of the flat request buses
  logic [1:0]    op_a    [NREQ];
  logic [AW-1:0] addr_a  [NREQ];
  logic [DW-1:0] wdata_a [NREQ];
  logic [DW-1:0] cmp_a   [NREQ];

  for (genvar i = 0; i < NREQ; i++) begin : g_unpack
    assign op_a[i]    = req_op[2*i +: 2];
    assign addr_a[i]  = req_addr[AW*i +: AW];
    assign wdata_a[i] = req_wdata[DW*i +: DW];
    assign cmp_a[i]   = req_cmp[DW*i +: DW];
  end

  st_e              st;
  logic [NREQ-1:0]  gnt;
  logic [IDX_W-1:0] gnt_idx;
  logic             gnt_any;

  casmem_rr_arb #(.N(NREQ), .IDX_W(IDX_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (st == ST_IDLE),
    .req     (req_valid),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  assign req_ready = gnt;

  op_e           sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic [DW-1:0] sel_cmp;

  assign sel_op    = op_e'(op_a[gnt_idx]);
  assign sel_addr  = addr_a[gnt_idx];
  assign sel_wdata = wdata_a[gnt_idx];
  assign sel_cmp   = cmp_a[gnt_idx];

  // swap context held across the store cycle
  logic [AW-1:0]   cas_addr;
  logic [DW-1:0]   cas_cmp;
  logic [DW-1:0]   cas_new;
  logic [DW-1:0]   cas_old;
  logic [NREQ-1:0] cas_owner;
  logic            cas_match;

  assign cas_match = (cas_old == cas_cmp);

  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always_comb begin
    if (st == ST_CAS_WR) begin
      wr_en   = cas_match;
      wr_addr = cas_addr;
      wr_data = cas_new;
    end else begin
      wr_en   = gnt_any && (sel_op == OP_WRITE);
      wr_addr = sel_addr;
      wr_data = sel_wdata;
    end
  end

  casmem_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (sel_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      rsp_valid   <= '0;
      rsp_data    <= '0;
      rsp_swapped <= 1'b0;
      cas_addr    <= '0;
      cas_cmp     <= '0;
      cas_new     <= '0;
      cas_old     <= '0;
      cas_owner   <= '0;
    end else begin
      rsp_valid   <= '0;
      rsp_swapped <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (gnt_any) begin
            case (sel_op)
              OP_CAS: begin
                st        <= ST_CAS_WR;
                cas_addr  <= sel_addr;
                cas_cmp   <= sel_cmp;
                cas_new   <= sel_wdata;
                cas_old   <= rd_data;
                cas_owner <= gnt;
              end
              OP_WRITE: ;
              default: begin
                rsp_valid <= gnt;
                rsp_data  <= rd_data;
              end
            endcase
          end
        end
        ST_CAS_WR: begin
          st          <= ST_IDLE;
          rsp_valid   <= cas_owner;
          rsp_data    <= cas_old;
          rsp_swapped <= cas_match;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/casmem_checker.sv
module casmem_checker #(
  parameter int NREQ = 3,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREQ-1:0]    req_valid,
  input logic [NREQ-1:0]    req_ready,
  input logic [2*NREQ-1:0]  req_op,
  input logic [NREQ-1:0]    rsp_valid,
  input logic               rsp_swapped
);
  logic [NREQ-1:0] is_cas, is_wr, is_rd;

  for (genvar i = 0; i < NREQ; i++) begin : g_dec
    assign is_cas[i] = (req_op[2*i +: 2] == 2'd2);
    assign is_wr[i]  = (req_op[2*i +: 2] == 2'd1);
    assign is_rd[i]  = !is_cas[i] && !is_wr[i];
  end

  logic cas_acc, wr_acc, rd_acc;
  assign cas_acc = |(req_ready & req_valid & is_cas);
  assign wr_acc  = |(req_ready & req_valid & is_wr);
  assign rd_acc  = |(req_ready & req_valid & is_rd);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R7
  AST_GNT_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R7
  AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_valid) && !$past(cas_acc)) |-> (|req_ready)); // R7
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid)); // R8
  AST_CAS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cas_acc |=> (req_ready == '0)); // R5
  AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> ((rsp_valid == $past(req_ready)) && !rsp_swapped)); // R1
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (rsp_valid == '0)); // R2
  AST_CAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cas_acc |=> ##1 (rsp_valid == $past(req_ready, 2))); // R3
  AST_FLAG_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_swapped |-> (|rsp_valid)); // R4
endmodule

bind casmem_unit casmem_checker #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .rsp_valid   (rsp_valid),
  .rsp_swapped (rsp_swapped)
);

// File: tb/test_casmem_unit.sv
module test_casmem_unit;
  localparam int NREQ   = 3;
  localparam int AW     = 4;
  localparam int DW     = 16;
  localparam int CLK_NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [1:0]    b_valid_op [NREQ];
  logic          b_valid    [NREQ];
  logic [AW-1:0] b_addr     [NREQ];
  logic [DW-1:0] b_wdata    [NREQ];
  logic [DW-1:0] b_cmp      [NREQ];

  logic [NREQ-1:0]    req_valid, req_ready, rsp_valid;
  logic [2*NREQ-1:0]  req_op;
  logic [AW*NREQ-1:0] req_addr;
  logic [DW*NREQ-1:0] req_wdata, req_cmp;
  logic [DW-1:0]      rsp_data;
  logic               rsp_swapped;

  for (genvar i = 0; i < NREQ; i++) begin : g_pack
    assign req_valid[i]          = b_valid[i];
    assign req_op[2*i +: 2]      = b_valid_op[i];
    assign req_addr[AW*i +: AW]  = b_addr[i];
    assign req_wdata[DW*i +: DW] = b_wdata[i];
    assign req_cmp[DW*i +: DW]   = b_cmp[i];
  end

  casmem_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) i_casmem_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_swapped(rsp_swapped)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int id, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [DW-1:0] cp);
    b_valid[id] = 1'b1; b_valid_op[id] = op; b_addr[id] = a;
    b_wdata[id] = wd;   b_cmp[id] = cp;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NREQ; i++) begin
      b_valid[i] = 1'b0; b_valid_op[i] = 2'd0; b_addr[i] = '0;
      b_wdata[i] = '0;   b_cmp[i] = '0;
    end
  endtask

  // fields: op(2) id(2) addr(4) wdata(16) cmp(16) expected data(16) expected flag(1)
  localparam int NV = 12;
  localparam logic [56:0] VEC [NV] = '{
    {2'd1, 2'd0, 4'd3,  16'h1234, 16'h0000, 16'h0000, 1'b0},
    {2'd0, 2'd1, 4'd3,  16'h0000, 16'h0000, 16'h1234, 1'b0},
    {2'd2, 2'd2, 4'd3,  16'hBEEF, 16'h1234, 16'h1234, 1'b1},
    {2'd0, 2'd0, 4'd3,  16'h0000, 16'h0000, 16'hBEEF, 1'b0},
    {2'd2, 2'd1, 4'd3,  16'h5555, 16'h1234, 16'hBEEF, 1'b0},
    {2'd3, 2'd2, 4'd3,  16'h0000, 16'h0000, 16'hBEEF, 1'b0},
    {2'd0, 2'd0, 4'd15, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    {2'd1, 2'd1, 4'd15, 16'hFFFF, 16'h0000, 16'h0000, 1'b0},
    {2'd2, 2'd0, 4'd15, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b1},
    {2'd0, 2'd1, 4'd15, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    {2'd2, 2'd2, 4'd0,  16'h00A5, 16'h0000, 16'h0000, 1'b1},
    {2'd0, 2'd2, 4'd0,  16'h0000, 16'h0000, 16'h00A5, 1'b0}
  };

  initial begin
    #(CLK_NS * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state at the ports
    #1;
    chk("R9 no response after reset", 32'(rsp_valid), 32'd0);
    chk("R9 no grant without valid", 32'(req_ready), 32'd0);

    // R9/R6: requester 0 wins first when all contend
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) drive(i, 2'd0, 4'd7, '0, '0);
    #1;
    chk("R9 first priority to requester 0", 32'(req_ready), 32'b001);
    @(posedge clk); @(negedge clk);
    clear_all();
    chk("R9 memory cleared by reset", 32'(rsp_data), 32'h0);

    // table of single-requester operations
    for (int v = 0; v < NV; v++) begin
      logic [1:0]    op;
      int            id;
      logic [AW-1:0] a;
      logic [DW-1:0] wd, cp, ed;
      logic          es;
      op = VEC[v][56:55]; id = int'(VEC[v][54:53]); a = VEC[v][52:49];
      wd = VEC[v][48:33]; cp = VEC[v][32:17]; ed = VEC[v][16:1]; es = VEC[v][0];
      @(negedge clk);
      drive(id, op, a, wd, cp);
      #1;
      chk("R7 lone requester granted", 32'(req_ready), 32'(1 << id));
      @(posedge clk); @(negedge clk);
      clear_all();
      if (op == 2'd1) begin
        chk("R2 write gives no response", 32'(rsp_valid), 32'd0);
      end else if (op == 2'd2) begin
        chk("R5 no grant during swap store cycle", 32'(req_ready), 32'd0);
        chk("R3 swap response not yet due", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        if (es) begin
          chk("R3 swap response owner", 32'(rsp_valid), 32'(1 << id));
          chk("R3 swap old value", 32'(rsp_data), 32'(ed));
          chk("R3 swap flag", 32'(rsp_swapped), 32'd1);
        end else begin
          chk("R4 mismatch response owner", 32'(rsp_valid), 32'(1 << id));
          chk("R4 mismatch old value", 32'(rsp_data), 32'(ed));
          chk("R4 mismatch flag", 32'(rsp_swapped), 32'd0);
        end
      end else begin
        chk("R1 read response owner", 32'(rsp_valid), 32'(1 << id));
        chk("R1 read data", 32'(rsp_data), 32'(ed));
        chk("R1 read flag low", 32'(rsp_swapped), 32'd0);
        chk("R8 single response bit", 32'($countones(rsp_valid)), 32'd1);
      end
    end

    // R5: a read to the same word arrives mid-swap
    @(negedge clk);
    drive(2, 2'd1, 4'd5, 16'h0077, '0);
    @(posedge clk); @(negedge clk);
    clear_all();
    drive(0, 2'd2, 4'd5, 16'h0999, 16'h0077);
    #1;
    chk("R7 swap requester granted", 32'(req_ready), 32'b001);
    @(posedge clk); @(negedge clk);
    clear_all();
    drive(1, 2'd0, 4'd5, '0, '0);
    #1;
    chk("R5 contender held during swap", 32'(req_ready), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R3 contended swap owner", 32'(rsp_valid), 32'b001);
    chk("R3 contended swap old", 32'(rsp_data), 32'h0077);
    chk("R3 contended swap flag", 32'(rsp_swapped), 32'd1);
    chk("R5 contender granted after swap", 32'(req_ready), 32'b010);
    @(posedge clk); @(negedge clk);
    clear_all();
    chk("R5 contender sees new value", 32'(rsp_data), 32'h0999);
    chk("R8 contender response owner", 32'(rsp_valid), 32'b010);

    // R6: rotation with all requesters valid
    begin
      int prev;
      prev = -1;
      @(negedge clk);
      for (int i = 0; i < NREQ; i++) drive(i, 2'd0, 4'd3, '0, '0);
      for (int n = 0; n < 6; n++) begin
        int g;
        #1;
        g = -1;
        for (int i = 0; i < NREQ; i++) if (req_ready[i]) g = i;
        if (prev >= 0) chk("R6 round-robin order", 32'(g), 32'((prev + 1) % NREQ));
        else           chk("R7 some requester granted", 32'($countones(req_ready)), 32'd1);
        prev = g;
        @(posedge clk); @(negedge clk);
      end
      clear_all();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule